// File: doc/BRIEF.md
# Sliced Data Ancillary Packet Formatter

This block takes the bytes sliced from one video line and wraps them into an ancillary packet. It then places that packet into an 8-bit component video byte stream while the line is in horizontal blanking. Payload bytes arrive on a simple valid/last stream. The block stores them together with the line's descriptors: field, whether the line lies inside the vertical blanking interval, the service format, the 10-bit line number, two match flags and a single-error flag.

The packet is sent when the next end-of-active-video strobe arrives. A packet therefore always appears one line ahead of the line its data came from. The stream starts with a three-byte preamble, followed by a parity-protected header and the data bytes. An 8-bit checksum of the data bytes follows, and zero fill pads the packet to a whole number of 4-byte words. One packet can be held at a time. Capture and transmission share a single store of `MAX_BYTES` bytes.

Top module: `anc_pkt_fmt`

## Requirements
- R1: The first packet byte appears on `pkt_data` in the cycle right after a sampled `eav_done` that finds a payload pending. Bytes 0, 1 and 2 are 00h, FFh and FFh.
- R2: Byte 3 is the data ID. It is 91h for field 1 inside the blanking interval, 53h for field 1 outside it, 55h for field 2 inside it and 97h for field 2 outside it. `fld_sel` = 0 selects field 1, and `in_vbi` = 1 means the line is inside the blanking interval.
- R3: In bytes 3, 4 and 5, bit 6 is the even parity (XOR) of bits 5:0, and bit 7 is the inverse of bit 6.
- R4: Bits 5:0 of byte 4 equal `svc_mode[5:0]` as captured with the payload. Bits 7:6 of `svc_mode` have no effect.
- R5: Bits 5:0 of byte 5 hold N = ceil((K+1)/4), where K is the number of data bytes kept. The packet is exactly 4N+8 bytes long.
- R6: Byte 6 is line number bits 7:0. Byte 7 holds line bits 9:8 in bits 1:0, match 2 in bit 2, match 1 in bit 3 and the error flag in bit 4, with bits 7:5 at zero. All of these are the values sampled with the payload's last marker.
- R7: Bytes 8 to 8+K-1 are the kept data bytes in arrival order. Byte 8+K is the sum of those bytes modulo 256.
- R8: Every byte after the checksum up to the end of the packet is 00h.
- R9: `busy` and `pkt_valid` are both low after reset. They are high together on every cycle from the first preamble byte to the last fill byte, with one byte per cycle and no gaps.
- R10: A last marker with `pl_valid` low and no bytes before it produces a 12-byte packet with N = 1 and a checksum of 00h.
- R11: `eav_done` has no effect when no payload is pending or while a packet is being sent.
- R12: Payload bytes and last markers that arrive while a packet is pending or being sent are dropped. This holds until the cycle after the last fill byte.
- R13: Bytes beyond `MAX_BYTES` (default 64) in one payload are dropped. N and the checksum reflect only the bytes kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte qualifier |
| pl_last | input | 1 | Marks the end of the line's payload; samples the descriptors |
| fld_sel | input | 1 | 0 = field 1, 1 = field 2 |
| in_vbi | input | 1 | 1 = line inside the vertical blanking interval |
| svc_mode | input | 8 | Line mode byte; bits 5:0 are the service format |
| line_num | input | 10 | Source line number |
| match1 | input | 1 | Match 1 flag |
| match2 | input | 1 | Match 2 flag |
| edc_err | input | 1 | Single error detected flag |
| eav_done | input | 1 | Strobe: end-of-active-video code has just been sent |
| pkt_data | output | 8 | Packet byte |
| pkt_valid | output | 1 | Packet byte valid |
| busy | output | 1 | High while a packet is being sent |

## Verification
Some properties are checked by the bound assertions on every cycle, for any traffic:

- the preamble values;
- that the data ID is one of the four legal codes;
- the parity and inverse-parity bits on the three protected header bytes;
- the zero bits in byte 7;
- that each packet's length matches the word count it announces;
- that a packet starts only after an end-of-video strobe.

Other behaviour depends on what went in, so only the bench scenarios can show it:

- the data ID chosen for each field and blanking combination;
- the payload order and checksum;
- the fill content;
- the empty-payload case;
- truncation at capacity;
- dropping of bytes and strobes while a packet is pending or in flight.

// File: rtl/anc_pkg.sv
`timescale 1ns/1ps
package anc_pkg;

   // Descriptors sampled together with the payload's last marker.
   typedef struct packed {
      logic       fld;
      logic       vbi;
      logic [5:0] fmt;
      logic [9:0] line;
      logic       m1;
      logic       m2;
      logic       err;
   } anc_meta_t;

   localparam logic [7:0] PRE_LO  = 8'h00;
   localparam logic [7:0] PRE_HI  = 8'hFF;
   localparam logic [7:0] PAD_VAL = 8'h00;
   localparam int         HDR_LEN = 8;
   localparam int         WORD_B  = 4;

   // 6-bit value with even parity in bit 6 and its inverse in bit 7.
   function automatic logic [7:0] prot6(input logic [5:0] v);
      logic p;
      p = ^v;
      return {~p, p, v};
   endfunction

   // Raw 6-bit data ID: bit 2 = field, bit 1 = outside blanking, bit 0 = 1.
   function automatic logic [5:0] did_raw(input logic fld, input logic vbi);
      return {3'b010, fld, ~vbi, 1'b1};
   endfunction

endpackage

// File: rtl/anc_pl_store.sv
`timescale 1ns/1ps
module anc_pl_store #(
   parameter  int MAX_BYTES = 64,
   localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
   localparam int CW = $clog2(MAX_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          clr,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] cnt,
   output logic [7:0]    sum
);

   logic [7:0] mem [MAX_BYTES];
   logic       take;

   assign take = wr_en && (cnt < CW'(MAX_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_BYTES; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < MAX_BYTES; i++) begin
            if (take && (cnt == CW'(i))) mem[i] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sum <= '0;
      end else if (clr) begin
         cnt <= '0;
         sum <= '0;
      end else if (take) begin
         cnt <= cnt + CW'(1);
         sum <= sum + wr_data;
      end
   end

   generate
      if ((1 << AW) == MAX_BYTES) begin : g_pow2
         assign rd_data = mem[rd_idx];
      end else begin : g_guard
         assign rd_data = (int'(rd_idx) < MAX_BYTES) ? mem[rd_idx] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/anc_pkt_seq.sv
`timescale 1ns/1ps
module anc_pkt_seq #(
   parameter int IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] last_idx,
   output logic          sending,
   output logic [IW-1:0] idx,
   output logic          done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sending <= 1'b0;
         idx     <= '0;
      end else if (!sending) begin
         idx <= '0;
         if (start) sending <= 1'b1;
      end else if (idx == last_idx) begin
         sending <= 1'b0;
         idx     <= '0;
      end else begin
         idx <= idx + IW'(1);
      end
   end

   assign done = sending && (idx == last_idx);

endmodule

// File: rtl/anc_pkt_bytes.sv
`timescale 1ns/1ps
module anc_pkt_bytes
   import anc_pkg::*;
#(
   parameter  int MAX_BYTES = 64,
   localparam int AW      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
   localparam int CW      = $clog2(MAX_BYTES + 1),
   localparam int LEN_MAX = HDR_LEN + WORD_B * ((MAX_BYTES + WORD_B) / WORD_B),
   localparam int IW      = $clog2(LEN_MAX)
) (
   input  logic [IW-1:0] idx,
   input  anc_meta_t     meta,
   input  logic [CW-1:0] cnt,
   input  logic [7:0]    sum,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] rd_idx,
   output logic [7:0]    byte_out,
   output logic [IW-1:0] last_idx
);

   logic [CW:0]   words;
   logic [5:0]    words6;
   logic [IW-1:0] rel;
   logic [IW-1:0] cnt_w;

   // Words after the header: data bytes plus the checksum, rounded up.
   assign words    = ({1'b0, cnt} + (CW+1)'(WORD_B)) >> 2;
   assign words6   = 6'(words);
   assign last_idx = IW'({words, 2'b00}) + IW'(HDR_LEN - 1);
   assign rel      = idx - IW'(HDR_LEN);
   assign cnt_w    = IW'(cnt);
   assign rd_idx   = rel[AW-1:0];

   always_comb begin
      unique case (idx)
         IW'(0):  byte_out = PRE_LO;
         IW'(1):  byte_out = PRE_HI;
         IW'(2):  byte_out = PRE_HI;
         IW'(3):  byte_out = prot6(did_raw(meta.fld, meta.vbi));
         IW'(4):  byte_out = prot6(meta.fmt);
         IW'(5):  byte_out = prot6(words6);
         IW'(6):  byte_out = meta.line[7:0];
         IW'(7):  byte_out = {3'b000, meta.err, meta.m1, meta.m2, meta.line[9:8]};
         default: begin
            if (rel < cnt_w)       byte_out = rd_data;
            else if (rel == cnt_w) byte_out = sum;
            else                   byte_out = PAD_VAL;
         end
      endcase
   end

endmodule

// File: rtl/anc_pkt_fmt.sv
`timescale 1ns/1ps
module anc_pkt_fmt
   import anc_pkg::*;
#(
   parameter int MAX_BYTES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] pl_data,
   input  logic       pl_valid,
   input  logic       pl_last,
   input  logic       fld_sel,
   input  logic       in_vbi,
   input  logic [7:0] svc_mode,
   input  logic [9:0] line_num,
   input  logic       match1,
   input  logic       match2,
   input  logic       edc_err,
   input  logic       eav_done,
   output logic [7:0] pkt_data,
   output logic       pkt_valid,
   output logic       busy
);

   localparam int AW      = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
   localparam int CW      = $clog2(MAX_BYTES + 1);
   localparam int LEN_MAX = HDR_LEN + WORD_B * ((MAX_BYTES + WORD_B) / WORD_B);
   localparam int IW      = $clog2(LEN_MAX);

   generate
      if (MAX_BYTES < 1)
         $error("MAX_BYTES must be at least 1");
      if ((MAX_BYTES + WORD_B) / WORD_B > 63)
         $error("MAX_BYTES too large for a 6-bit word count");
      if (IW < AW)
         $error("index width narrower than store address");
   endgenerate

   logic          pend;
   anc_meta_t     meta_q;
   logic          sending;
   logic          done;
   logic [IW-1:0] idx;
   logic [IW-1:0] last_idx;
   logic [AW-1:0] rd_idx;
   logic [7:0]    rd_data;
   logic [CW-1:0] cnt;
   logic [7:0]    sum;
   logic [7:0]    byte_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         meta_q <= '0;
      end else if (done) begin
         pend <= 1'b0;
      end else if (!pend && pl_last) begin
         pend   <= 1'b1;
         meta_q <= '{fld: fld_sel, vbi: in_vbi, fmt: svc_mode[5:0],
                     line: line_num, m1: match1, m2: match2, err: edc_err};
      end
   end

   anc_pl_store #(.MAX_BYTES(MAX_BYTES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pl_valid && !pend),
      .wr_data (pl_data),
      .clr     (done),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cnt     (cnt),
      .sum     (sum)
   );

   anc_pkt_seq #(.IW(IW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (eav_done && pend),
      .last_idx (last_idx),
      .sending  (sending),
      .idx      (idx),
      .done     (done)
   );

   anc_pkt_bytes #(.MAX_BYTES(MAX_BYTES)) u_bytes (
      .idx      (idx),
      .meta     (meta_q),
      .cnt      (cnt),
      .sum      (sum),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .byte_out (byte_out),
      .last_idx (last_idx)
   );

   assign pkt_data  = byte_out;
   assign pkt_valid = sending;
   assign busy      = sending;

endmodule

// File: rtl/anc_pkt_fmt_chk.sv
`timescale 1ns/1ps
module anc_pkt_fmt_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] pl_data,
   input logic       pl_valid,
   input logic       pl_last,
   input logic       fld_sel,
   input logic       in_vbi,
   input logic [7:0] svc_mode,
   input logic [9:0] line_num,
   input logic       match1,
   input logic       match2,
   input logic       edc_err,
   input logic       eav_done,
   input logic [7:0] pkt_data,
   input logic       pkt_valid,
   input logic       busy
);

   logic [8:0] pos;
   logic [5:0] nw_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos    <= '0;
         nw_cap <= '0;
      end else begin
         pos <= pkt_valid ? pos + 9'd1 : 9'd0;
         if (pkt_valid && pos == 9'd5) nw_cap <= pkt_data[5:0];
      end
   end

   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> pkt_data == 8'h00); // R1

   AST_PREAMBLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && (pos == 9'd1 || pos == 9'd2)) |-> pkt_data == 8'hFF); // R1

   AST_DID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pos == 9'd3) |->
         (pkt_data == 8'h91 || pkt_data == 8'h53 || pkt_data == 8'h55 || pkt_data == 8'h97)); // R2

   AST_HDR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pos >= 9'd3 && pos <= 9'd5) |->
         (pkt_data[6] == ^pkt_data[5:0] && pkt_data[7] == ~pkt_data[6])); // R3

   AST_LINE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && pos == 9'd7) |-> pkt_data[7:5] == 3'b000); // R6

   AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pkt_valid) |-> pos == ({1'b0, nw_cap, 2'b00} + 9'd8)); // R5

   AST_START_ON_EAV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_valid) |-> $past(eav_done)); // R11

endmodule

bind anc_pkt_fmt anc_pkt_fmt_chk u_chk (.*);

// File: tb/anc_pkt_fmt_tb.sv
`timescale 1ns/1ps
module anc_pkt_fmt_tb;

   localparam int MAXB = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pl_data = '0;
   logic       pl_valid = 1'b0;
   logic       pl_last = 1'b0;
   logic       fld_sel = 1'b0;
   logic       in_vbi = 1'b0;
   logic [7:0] svc_mode = '0;
   logic [9:0] line_num = '0;
   logic       match1 = 1'b0;
   logic       match2 = 1'b0;
   logic       edc_err = 1'b0;
   logic       eav_done = 1'b0;
   logic [7:0] pkt_data;
   logic       pkt_valid;
   logic       busy;

   always #10 clk = ~clk;

   anc_pkt_fmt #(.MAX_BYTES(MAXB)) u_dut (.*);

   int checks = 0;
   int errors = 0;
   int cap_n = 0;
   int busy_mis = 0;
   int exp_n = 0;
   int exp_len = 0;
   logic [7:0] cap  [0:127];
   logic [7:0] expb [0:127];

   // Table: len, seed, field, in_vbi, mode, line, match1, match2, err
   localparam int NV = 6;
   localparam logic [38:0] VEC [0:NV-1] = '{
      {8'd2,  8'h41, 1'b0, 1'b1, 8'h01, 10'd21,  1'b1, 1'b0, 1'b0},
      {8'd3,  8'hF0, 1'b1, 1'b1, 8'h09, 10'h115, 1'b0, 1'b1, 1'b0},
      {8'd4,  8'h80, 1'b0, 1'b0, 8'h3F, 10'h2FF, 1'b0, 1'b0, 1'b1},
      {8'd7,  8'hC3, 1'b1, 1'b0, 8'hC2, 10'h3A0, 1'b1, 1'b1, 1'b1},
      {8'd43, 8'h10, 1'b0, 1'b1, 8'h40, 10'd10,  1'b0, 1'b0, 1'b0},
      {8'd1,  8'hFF, 1'b1, 1'b1, 8'h2A, 10'h001, 1'b1, 1'b0, 1'b1}
   };

   always @(negedge clk) begin
      if (pkt_valid && cap_n < 128) begin
         cap[cap_n] = pkt_data;
         cap_n++;
      end
      if (rst_n && busy !== pkt_valid) busy_mis++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pay(input logic [7:0] seed, input int k);
      return seed + 8'(k * 29);
   endfunction

   function automatic logic [7:0] eprot(input logic [5:0] v);
      logic p;
      p = ^v;
      return {~p, p, v};
   endfunction

   task automatic load(input int len, input logic [7:0] seed, input logic f, input logic v,
                       input logic [7:0] md, input logic [9:0] ln,
                       input logic a1, input logic a2, input logic er);
      @(negedge clk);
      fld_sel = f; in_vbi = v; svc_mode = md; line_num = ln;
      match1 = a1; match2 = a2; edc_err = er;
      if (len == 0) begin
         pl_last = 1'b1;
         @(negedge clk);
      end else begin
         for (int k = 0; k < len; k++) begin
            pl_data  = pay(seed, k);
            pl_valid = 1'b1;
            pl_last  = (k == len - 1);
            @(negedge clk);
         end
      end
      pl_valid = 1'b0;
      pl_last  = 1'b0;
   endtask

   task automatic fire();
      @(negedge clk);
      eav_done = 1'b1;
      @(negedge clk);
      eav_done = 1'b0;
   endtask

   task automatic wait_pkt();
      int t;
      t = 0;
      while (!pkt_valid && t < 40) begin @(negedge clk); t++; end
      while (pkt_valid && t < 400) begin @(negedge clk); t++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic build_exp(input int len, input logic [7:0] seed, input logic f, input logic v,
                            input logic [7:0] md, input logic [9:0] ln,
                            input logic a1, input logic a2, input logic er);
      int nw;
      logic [7:0] s;
      nw = (len + 4) / 4;
      exp_len = len;
      expb[0] = 8'h00; expb[1] = 8'hFF; expb[2] = 8'hFF;
      case ({f, v})
         2'b01:   expb[3] = 8'h91;
         2'b00:   expb[3] = 8'h53;
         2'b11:   expb[3] = 8'h55;
         default: expb[3] = 8'h97;
      endcase
      expb[4] = eprot(md[5:0]);
      expb[5] = eprot(6'(nw));
      expb[6] = ln[7:0];
      expb[7] = {3'b000, er, a1, a2, ln[9:8]};
      s = 8'h00;
      for (int k = 0; k < len; k++) begin
         expb[8 + k] = pay(seed, k);
         s = s + pay(seed, k);
      end
      expb[8 + len] = s;
      exp_n = 8 + 4 * nw;
      for (int k = 9 + len; k < exp_n; k++) expb[k] = 8'h00;
   endtask

   task automatic compare();
      string tag;
      chk(cap_n == exp_n, "R5 length", cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++) begin
         if (i < 3)                  tag = "R1 preamble";
         else if (i == 3)            tag = "R2 data id";
         else if (i == 4)            tag = "R4 format";
         else if (i == 5)            tag = "R5 word count";
         else if (i < 8)             tag = "R6 line/flags";
         else if (i < 8 + exp_len)   tag = "R7 data";
         else if (i == 8 + exp_len)  tag = "R7 checksum";
         else                        tag = "R8 fill";
         chk(cap[i] == expb[i], tag, cap[i], expb[i]);
         if (i >= 3 && i <= 5)
            chk(cap[i][6] == ^cap[i][5:0] && cap[i][7] == ~cap[i][6], "R3 parity", cap[i], expb[i]);
      end
   endtask

   task automatic run(input int len, input int keep, input logic [7:0] seed, input logic f,
                      input logic v, input logic [7:0] md, input logic [9:0] ln,
                      input logic a1, input logic a2, input logic er);
      cap_n = 0;
      load(len, seed, f, v, md, ln, a1, a2, er);
      fire();
      wait_pkt();
      build_exp(keep, seed, f, v, md, ln, a1, a2, er);
      compare();
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(pkt_valid == 1'b0, "R9 reset valid", pkt_valid, 0);
      chk(busy == 1'b0, "R9 reset busy", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11: strobe with nothing pending
      cap_n = 0;
      fire();
      repeat (10) @(negedge clk);
      chk(cap_n == 0, "R11 idle strobe", cap_n, 0);

      // Table of packets (R1-R8)
      for (int i = 0; i < NV; i++) begin
         logic [38:0] e;
         e = VEC[i];
         run(int'(e[38:31]), int'(e[38:31]), e[30:23], e[22], e[21], e[20:13], e[12:3],
             e[2], e[1], e[0]);
      end

      // R10: empty payload
      run(0, 0, 8'h00, 1'b1, 1'b0, 8'h05, 10'h1FE, 1'b0, 1'b1, 1'b0);
      chk(cap_n == 12, "R10 empty length", cap_n, 12);
      chk(cap[8] == 8'h00, "R10 empty checksum", cap[8], 0);

      // R13: overflow beyond capacity
      run(MAXB + 6, MAXB, 8'h37, 1'b0, 1'b1, 8'h03, 10'd14, 1'b1, 1'b1, 1'b0);

      // R12: second payload while first pending is dropped
      cap_n = 0;
      load(5, 8'h22, 1'b0, 1'b1, 8'h02, 10'd20, 1'b0, 1'b0, 1'b0);
      load(3, 8'h99, 1'b1, 1'b0, 8'h04, 10'h055, 1'b1, 1'b1, 1'b1);
      fire();
      wait_pkt();
      build_exp(5, 8'h22, 1'b0, 1'b1, 8'h02, 10'd20, 1'b0, 1'b0, 1'b0);
      compare();
      chk(cap[6] == 8'd20, "R12 pending payload kept", cap[6], 20);

      // R12 / R11: payload and strobe during transmission
      cap_n = 0;
      load(20, 8'h07, 1'b1, 1'b1, 8'h01, 10'd21, 1'b0, 1'b1, 1'b0);
      fire();
      load(3, 8'hAB, 1'b0, 1'b0, 8'h00, 10'd99, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      eav_done = 1'b1;
      @(negedge clk);
      eav_done = 1'b0;
      chk(busy == 1'b1, "R11 still busy", busy, 1);
      wait_pkt();
      build_exp(20, 8'h07, 1'b1, 1'b1, 8'h01, 10'd21, 1'b0, 1'b1, 1'b0);
      compare();
      cap_n = 0;
      fire();
      repeat (10) @(negedge clk);
      chk(cap_n == 0, "R12 dropped during busy", cap_n, 0);

      chk(busy_mis == 0, "R9 busy tracks valid", busy_mis, 0);
      report();
      $finish;
   end

endmodule